// File: doc/BRIEF.md
# Nibble-Accessed Interval Timer

An eight-bit up-counter that sits beside a four-bit processor datapath. Once started it advances by one on every prescaled tick. The tick rate is the system clock divided by 2^n. From FFh it rolls over to 00h and keeps counting. Each rollover raises a timer flag. That flag stays up until an interrupt acknowledge or a flag-testing branch pulses the clear input.

Software can preset the count in one step from an eight-bit immediate. It can also write either four-bit half from the accumulator. While the counter is stopped, a half-write lands on the next clock. While it runs, the written half is parked and merged in at the next prescaled tick. Both halves of the live count are always visible on two four-bit read ports.

All control and data pins are plain strobes and levels. There is no valid/ready handshake and there is no back-pressure: every load, write, start, stop and clear is taken in the cycle it is presented. The divider exponent is a static setting captured while reset is held.

Top module: `nib_timer`

## Requirements
- R1: While and after reset, the count reads 00h, the counter is stopped and `tf_o` is 0.
- R2: While running with exponent n, the count advances by one every 2^n clock cycles. The first advance comes 2^n cycles after the edge that latched the start.
- R3: A tick at count FFh (with no load and no parked half) produces 00h and sets `tf_o` on that same edge, and counting continues. `tf_o` rises at no other time.
- R4: `stop_i` halts counting from the next edge; only `start_i` resumes it. If both are high in one cycle, stop wins. A stopped counter with no load or write holds its count.
- R5: `load_i` puts `load_val` into the count on the next edge, whether running or stopped. It overrides a tick and any half-write in that cycle, discards parked halves, and never sets `tf_o`.
- R6: While stopped, `wr_hi_i` replaces bits 7:4 and `wr_lo_i` replaces bits 3:0 with `wr_nib` on the next edge; the other half is kept.
- R7: While running, a half-write leaves the count unchanged until the next tick. That tick loads the count with the written half(s) merged into the current value instead of incrementing, and does not set `tf_o`.
- R8: `rd_hi` always shows count bits 7:4 and `rd_lo` bits 3:0.
- R9: `tf_clr_i` clears `tf_o` on the next edge, unless a rollover happens in that same cycle, in which case `tf_o` is 1.
- R10: `div_sel` is captured only while `rst_n` is low. The values 6 and anything above 13 select n = 0. Changes after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; also captures `div_sel` |
| div_sel | input | 4 | Divider exponent n (0..13, 6 reserved) |
| start_i | input | 1 | Start counting |
| stop_i | input | 1 | Stop counting |
| load_i | input | 1 | Load full 8-bit value |
| load_val | input | 8 | Immediate preload value |
| wr_hi_i | input | 1 | Write upper half from `wr_nib` |
| wr_lo_i | input | 1 | Write lower half from `wr_nib` |
| wr_nib | input | 4 | Half-write data |
| tf_clr_i | input | 1 | Clear request for the timer flag |
| rd_hi | output | 4 | Count bits 7:4 |
| rd_lo | output | 4 | Count bits 3:0 |
| tf_o | output | 1 | Timer flag |

## Verification
Some rules are checked on every cycle by the embedded properties:
- the captured exponent is always legal;
- a load lands on the next edge;
- an idle stopped counter holds, and a running half-write does not disturb the count before its tick;
- stop takes hold;
- the flag rises only on a rollover, and a rollover beats a clear.

Other behaviour needs the bench's behavioural model compared on every clock: the exact tick spacing for each exponent, the merged value at a parked-write tick, the rollover sequence, and the fallback and post-reset immunity of `div_sel`.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NIB_DEF = 4;
  localparam int unsigned DIV_DEF = 13;
  localparam int unsigned RSV_DEF = 6;

  // Map a requested exponent onto a legal one; illegal picks fall back to 0.
  function automatic int unsigned legal_div(input int unsigned s,
                                            input int unsigned dmax,
                                            input int unsigned rsv);
    return (s > dmax || s == rsv) ? 0 : s;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned DIV_MAX = tmr_pkg::DIV_DEF,
  parameter int unsigned RSV_SEL = tmr_pkg::RSV_DEF,
  parameter int unsigned SEL_W   = $clog2(DIV_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_raw,
  input  logic             run,
  output logic             tick
);
  localparam int unsigned PRE_W = (DIV_MAX > 0) ? DIV_MAX : 1;

  logic [SEL_W-1:0] sel_q;
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask;

  // exponent is captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= SEL_W'(tmr_pkg::legal_div(32'(sel_raw), DIV_MAX, RSV_SEL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre <= '0;
    else if (run) pre <= pre + 1'b1;
    else          pre <= '0;
  end

  assign mask = ~({PRE_W{1'b1}} << sel_q);
  assign tick = run && ((pre & mask) == mask);

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sel_q) != RSV_SEL) && (32'(sel_q) <= DIV_MAX)); // R10
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned NIB_W = tmr_pkg::NIB_DEF,
  localparam int unsigned CNT_W = 2 * NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [NIB_W-1:0] wr_nib,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] merged;
  logic [1:0]       pv;            // parked-half valid: [1]=upper, [0]=lower
  logic [NIB_W-1:0] pval [2];
  logic [1:0]       wr_req;
  logic             any_pend;

  assign wr_req   = {wr_hi, wr_lo};
  assign any_pend = |pv;

  // merge parked halves over the current count; one lane per half
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign merged[h*NIB_W +: NIB_W] = pv[h] ? pval[h] : cnt[h*NIB_W +: NIB_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pv[h]   <= 1'b0;
        pval[h] <= '0;
      end else if (load) begin
        pv[h]   <= 1'b0;
      end else if (run && wr_req[h]) begin
        pv[h]   <= 1'b1;
        pval[h] <= wr_nib;
      end else if (tick) begin
        pv[h]   <= 1'b0;
      end
    end
  end

  assign wrap_o = tick && !load && !any_pend && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick) begin
      cnt <= any_pend ? merged : cnt + 1'b1;
    end else if (!run) begin
      if (wr_hi) cnt[CNT_W-1:NIB_W] <= wr_nib;
      if (wr_lo) cnt[NIB_W-1:0]     <= wr_nib;
    end
  end

  assign count_o = cnt;

  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count_o == $past(load_val)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load && !wr_hi && !wr_lo) |=> $stable(count_o)); // R4
  AST_PARK_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (wr_hi || wr_lo) && !load && !tick) |=> $stable(count_o)); // R7
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic tf_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tf_o <= 1'b0;
    else if (set_i) tf_o <= 1'b1;
    else if (clr_i) tf_o <= 1'b0;
  end

  AST_WRAP_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> tf_o); // R9
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !tf_o); // R9
endmodule

// File: rtl/nib_timer.sv
module nib_timer #(
  parameter int unsigned NIB_W   = tmr_pkg::NIB_DEF,
  parameter int unsigned DIV_MAX = tmr_pkg::DIV_DEF,
  parameter int unsigned RSV_SEL = tmr_pkg::RSV_DEF,
  localparam int unsigned CNT_W  = 2 * NIB_W,
  localparam int unsigned SEL_W  = $clog2(DIV_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [NIB_W-1:0] wr_nib,
  input  logic             tf_clr_i,
  output logic [NIB_W-1:0] rd_hi,
  output logic [NIB_W-1:0] rd_lo,
  output logic             tf_o
);
  logic             run;
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] count;

  // stop has priority over start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run <= 1'b0;
    else if (stop_i)  run <= 1'b0;
    else if (start_i) run <= 1'b1;
  end

  tmr_prescale #(.DIV_MAX(DIV_MAX), .RSV_SEL(RSV_SEL), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel_raw(div_sel), .run(run), .tick(tick)
  );

  tmr_count #(.NIB_W(NIB_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .load(load_i), .load_val(load_val),
    .wr_hi(wr_hi_i), .wr_lo(wr_lo_i), .wr_nib(wr_nib),
    .count_o(count), .wrap_o(wrap)
  );

  tmr_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(wrap), .clr_i(tf_clr_i), .tf_o(tf_o)
  );

  assign rd_hi = count[CNT_W-1:NIB_W];
  assign rd_lo = count[NIB_W-1:0];

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !run); // R4
  AST_TF_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tf_o) |-> $past(wrap)); // R3
endmodule

// File: tb/sim_nib_timer.sv
`timescale 1ns/1ps
module sim_nib_timer;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [3:0] div_sel = '0;
  logic       start_i = 0, stop_i = 0, load_i = 0, wr_hi_i = 0, wr_lo_i = 0, tf_clr_i = 0;
  logic [7:0] load_val = '0;
  logic [3:0] wr_nib = '0;
  logic [3:0] rd_hi, rd_lo;
  logic       tf_o;

  nib_timer u0 (.*);

  int n_chk = 0, n_bad = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference state
  int mcnt, mrun, mtf, mpre, mn;
  bit mph, mpl;
  int mphv, mplv;

  function automatic int legal(int s);
    return (s == 6 || s > 13) ? 0 : s;
  endfunction

  function automatic bit tick_next();
    return mrun != 0 && (mpre % (1 << mn)) == (1 << mn) - 1;
  endfunction

  task automatic model_upd();
    bit tk, anyp, wrp;
    int nc;
    tk = tick_next(); anyp = mph || mpl; wrp = 0; nc = mcnt;
    if (load_i) begin
      nc = load_val; mph = 0; mpl = 0;
    end else begin
      if (tk) begin
        if (anyp) nc = ((mph ? mphv : (mcnt >> 4)) << 4) | (mpl ? mplv : (mcnt & 15));
        else begin nc = (mcnt + 1) & 255; wrp = (mcnt == 255); end
      end else if (mrun == 0) begin
        if (wr_hi_i) nc = (nc & 15) | (int'(wr_nib) << 4);
        if (wr_lo_i) nc = (nc & 240) | int'(wr_nib);
      end
      if (mrun != 0 && wr_hi_i) begin mph = 1; mphv = wr_nib; end else if (tk) mph = 0;
      if (mrun != 0 && wr_lo_i) begin mpl = 1; mplv = wr_nib; end else if (tk) mpl = 0;
    end
    mtf = wrp ? 1 : (tf_clr_i ? 0 : mtf);
    if (mrun != 0) mpre++; else mpre = 0;
    mrun = stop_i ? 0 : (start_i ? 1 : mrun);
    mcnt = nc;
  endtask

  task automatic check(int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_upd();
    @(negedge clk);
    check({rd_hi, rd_lo}, mcnt, "count (R8 read ports)");
    check(tf_o, mtf, "timer flag");
    {start_i, stop_i, load_i, wr_hi_i, wr_lo_i, tf_clr_i} = '0;
  endtask

  task automatic do_reset(int s);
    tag = "R1";
    rst_n = 0; div_sel = 4'(s);
    repeat (3) @(negedge clk);
    check({rd_hi, rd_lo}, 0, "reset count");
    check(tf_o, 0, "reset flag");
    mcnt = 0; mrun = 0; mtf = 0; mpre = 0; mph = 0; mpl = 0; mphv = 0; mplv = 0;
    mn = legal(s);
    rst_n = 1;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // ---- exponent 0 ----
    do_reset(0);
    repeat (3) step();                          // R1 stays stopped at 0
    tag = "R2"; start_i = 1; step(); repeat (20) step();
    tag = "R3"; repeat (250) step();            // rollover sets flag, keeps going
    tag = "R9"; tf_clr_i = 1; step(); step();
    for (int i = 0; i < 300 && !(mcnt == 255 && tick_next()); i++) step();
    tf_clr_i = 1; step(); step();               // rollover beats clear
    tag = "R8"; load_i = 1; load_val = 8'hA5; step();
    check(rd_hi, 4'hA, "upper read"); check(rd_lo, 4'h5, "lower read");
    tag = "R5"; load_i = 1; load_val = 8'h3C; wr_hi_i = 1; wr_nib = 4'h7; step();
    repeat (3) step();
    load_i = 1; load_val = 8'hFF; step();       // load at FF: no flag from load
    tf_clr_i = 1; step();
    load_i = 1; load_val = 8'h10; step();
    tag = "R4"; stop_i = 1; start_i = 1; step(); repeat (5) step();
    start_i = 1; step(); repeat (4) step();
    stop_i = 1; step(); repeat (6) step();
    tag = "R6"; wr_hi_i = 1; wr_nib = 4'h3; step();
    wr_lo_i = 1; wr_nib = 4'hC; step(); repeat (3) step();
    check({rd_hi, rd_lo}, 8'h3C, "stopped half-writes");

    // ---- exponent 2, then div_sel changed after reset ----
    do_reset(2);
    tag = "R10"; div_sel = 4'd5;
    start_i = 1; step(); repeat (40) step();
    tag = "R7"; wr_lo_i = 1; wr_nib = 4'h9; step(); repeat (10) step();
    wr_hi_i = 1; wr_lo_i = 1; wr_nib = 4'hE; step(); repeat (10) step();
    load_i = 1; load_val = 8'hFE; wr_lo_i = 1; wr_nib = 4'h1; step();
    wr_hi_i = 1; wr_nib = 4'hF; step();         // parked, merged at next tick
    repeat (12) step();
    tag = "R3"; load_i = 1; load_val = 8'hFD; step(); repeat (20) step();
    tag = "R9"; tf_clr_i = 1; step();
    for (int i = 0; i < 2000 && !(mcnt == 255 && tick_next()); i++) step();
    tf_clr_i = 1; step(); repeat (4) step();
    tag = "R2"; stop_i = 1; step(); start_i = 1; step(); repeat (12) step();

    // ---- reserved and out-of-range exponents ----
    do_reset(6);
    tag = "R10"; start_i = 1; step(); repeat (20) step();
    do_reset(15);
    tag = "R10"; start_i = 1; step(); repeat (10) step();

    // ---- largest exponent ----
    do_reset(13);
    tag = "R2"; load_i = 1; load_val = 8'hFF; step();
    start_i = 1; step(); repeat (8200) step();
    check(tf_o, 1, "flag after slow rollover");

    done = 1;
    summary();
    $finish;
  end
endmodule